// File: doc/BRIEF.md
# SCSI Target Data-Phase Parity and Halt Sequencer

This block sits on the data path of a SCSI target. Every byte it sends goes out one cycle later with a parity bit it generates itself. Every byte it receives is checked for parity. If a received byte fails the check, or the initiator raises its attention line, the block brings the transfer to a controlled stop. It does not stop at once. It first lets a small number of bytes through so that clock-domain crossings can settle. In synchronous mode it then waits until no offsets remain outstanding. On a receive, it finally waits until the staging FIFO has drained.

Two configuration bits come from a register interface. One suppresses halting altogether. The other makes the transmit side send the wrong parity on purpose, for diagnostics. A separate enable turns receive checking on. A sticky error flag records parity failures until software clears it. A resume strobe releases a completed halt. All inputs share one clock, and the reset is synchronous and active high.

Top module: `scsi_xfer_ctl`

## Requirements
- R1: With `cfg_force_even` low, each byte presented on `tx_valid` appears on `tx_out_data` one clock later with `tx_out_valid` high. Its `tx_out_par` makes the total count of ones across data and parity odd.
- R2: With `cfg_force_even` high, the registered transmit parity makes the total count of ones even. Every transmitted byte therefore carries bad parity.
- R3: When `cfg_chk_en` is high, a received byte whose data and parity together hold an even number of ones is a parity error. This holds whatever `cfg_force_even` is. When `cfg_chk_en` is low, no received byte is an error.
- R4: `perr_flag` sets on the clock after a parity error and stays set until a `perr_clr` strobe is given with no new error in that cycle.
- R5: With `cfg_no_halt` low and the sequencer idle, a parity error or a high `atn` raises `halt_pending` on the next clock.
- R6: With `cfg_no_halt` high, neither `atn` nor a parity error raises `halt_pending` or `halt`. The error flag still records the parity error.
- R7: After the halt request, up to three further byte strobes are allowed. Byte strobes come from `rx_valid` when `dir_rx` is high and from `tx_valid` otherwise. The slack window ends at the third strobe, or in the first cycle that offers no strobe. Two clocks after the window ends, `halt` rises, provided the R8 and R9 conditions already hold.
- R8: When `sync_mode` is high, the sequencer waits after the slack window until `offset_cnt` is zero. `halt` rises two clocks after the count reaches zero.
- R9: When `dir_rx` is high, `halt` rises only on the clock after `fifo_empty` is seen high.
- R10: `offset_cnt` rises by one on `req_sent`, falls by one on `ack_rcvd`, and stays the same when both are high. It never goes below zero.
- R11: While a halt is pending, further attention or parity errors do not restart or extend the sequence.
- R12: With `halt` high, a `resume` strobe drops `halt` on the next clock and returns the sequencer to idle.
- R13: After reset, `halt`, `halt_pending`, `perr_flag`, `tx_out_valid` and `offset_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_no_halt | input | 1 | Suppress halting on attention or parity error |
| cfg_force_even | input | 1 | Send even (bad) parity on transmitted bytes |
| cfg_chk_en | input | 1 | Enable receive parity checking |
| perr_clr | input | 1 | Clear strobe for the sticky parity-error flag |
| resume | input | 1 | Release a completed halt |
| dir_rx | input | 1 | 1 = receiving from the bus, 0 = sending |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_data | input | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Received byte |
| rx_par | input | 1 | Received parity bit |
| atn | input | 1 | Attention line from the initiator |
| sync_mode | input | 1 | Synchronous transfer mode |
| req_sent | input | 1 | A REQ was issued (offset grows) |
| ack_rcvd | input | 1 | An ACK came back (offset shrinks) |
| fifo_empty | input | 1 | Receive staging FIFO is empty |
| tx_out_valid | output | 1 | Registered transmit strobe |
| tx_out_data | output | 8 | Registered transmit byte |
| tx_out_par | output | 1 | Parity bit sent with the byte |
| perr_flag | output | 1 | Sticky parity-error flag |
| halt_pending | output | 1 | Halt requested but not yet complete |
| halt | output | 1 | Transfer halted |
| offset_cnt | output | 5 | Outstanding synchronous offsets |

## Verification
The hardest state to reach is a halt that is still held up after the slack window, because offsets remain outstanding or the FIFO still holds data. The stimulus builds up offsets with REQ pulses before raising attention. It then withholds the ACKs, or keeps the FIFO non-empty, for several cycles while checking that `halt` stays low. Only after that does it release the condition and check the exact cycle in which `halt` rises. A separate run keeps attention high through the whole slack window while bytes stream every cycle. This shows that the three-byte allowance is counted once and is not restarted.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_SLACK,
        HS_OFFSET,
        HS_DRAIN,
        HS_HALTED
    } halt_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              par;
    } tx_beat_t;

    // Parity bit that makes data plus parity hold an odd number of ones.
    function automatic logic odd_par_of(input logic [BYTE_W-1:0] d);
        return ~(^d);
    endfunction

    // True when data plus parity hold an odd number of ones.
    function automatic logic odd_ok(input logic [BYTE_W-1:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/scsi_par_gen.sv
module scsi_par_gen
    import scsi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              force_even,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output tx_beat_t          beat
);
    logic par_c;

    always_comb begin
        par_c = odd_par_of(in_data);
        if (force_even) begin
            par_c = ~par_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            if (in_valid) begin
                beat.data <= in_data;
                beat.par  <= par_c;
            end
        end
    end
endmodule

// File: rtl/scsi_par_chk.sv
module scsi_par_chk
    import scsi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic              clr,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_par,
    output logic              err_evt,
    output logic              err_flag
);
    always_comb begin
        err_evt = rx_valid && chk_en && !odd_ok(rx_data, rx_par);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (err_evt) begin
            err_flag <= 1'b1;
        end else if (clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/scsi_ofs_ctr.sv
module scsi_ofs_ctr #(
    parameter int OFS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [OFS_W-1:0] count,
    output logic             is_zero
);
    localparam logic [OFS_W-1:0] OFS_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (count != OFS_MAX) count <= count + 1'b1;
                2'b01: if (count != '0)      count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign is_zero = (count == '0);
endmodule

// File: rtl/scsi_halt_seq.sv
module scsi_halt_seq
    import scsi_xfer_pkg::*;
#(
    parameter int SLACK_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic strobe,
    input  logic sync_mode,
    input  logic ofs_zero,
    input  logic dir_rx,
    input  logic fifo_empty,
    input  logic resume,
    output logic pending,
    output logic halted
);
    localparam int SLK_W = $clog2(SLACK_MAX + 1);
    localparam logic [SLK_W-1:0] SLK_INIT = SLK_W'(SLACK_MAX);

    halt_state_e      state_q, state_d;
    logic [SLK_W-1:0] slk_q, slk_d;

    always_comb begin
        state_d = state_q;
        slk_d   = slk_q;
        unique case (state_q)
            HS_IDLE: begin
                if (req) begin
                    state_d = HS_SLACK;
                    slk_d   = SLK_INIT;
                end
            end
            HS_SLACK: begin
                if (strobe) begin
                    slk_d = slk_q - 1'b1;
                end
                if (!strobe || slk_q <= SLK_W'(1)) begin
                    state_d = HS_OFFSET;
                end
            end
            HS_OFFSET: begin
                if (!sync_mode || ofs_zero) begin
                    state_d = HS_DRAIN;
                end
            end
            HS_DRAIN: begin
                if (!dir_rx || fifo_empty) begin
                    state_d = HS_HALTED;
                end
            end
            HS_HALTED: begin
                if (resume) begin
                    state_d = HS_IDLE;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_IDLE;
            slk_q   <= '0;
        end else begin
            state_q <= state_d;
            slk_q   <= slk_d;
        end
    end

    assign pending = (state_q != HS_IDLE) && (state_q != HS_HALTED);
    assign halted  = (state_q == HS_HALTED);
endmodule

// File: rtl/scsi_xfer_ctl.sv
module scsi_xfer_ctl
    import scsi_xfer_pkg::*;
#(
    parameter int OFS_W     = 5,
    parameter int SLACK_MAX = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_no_halt,
    input  logic              cfg_force_even,
    input  logic              cfg_chk_en,
    input  logic              perr_clr,
    input  logic              resume,
    input  logic              dir_rx,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_par,
    input  logic              atn,
    input  logic              sync_mode,
    input  logic              req_sent,
    input  logic              ack_rcvd,
    input  logic              fifo_empty,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_par,
    output logic              perr_flag,
    output logic              halt_pending,
    output logic              halt,
    output logic [OFS_W-1:0]  offset_cnt
);
    tx_beat_t beat;
    logic     perr_evt;
    logic     ofs_zero;
    logic     halt_req;
    logic     strobe;

    scsi_par_gen u_gen (
        .clk        (clk),
        .rst        (rst),
        .force_even (cfg_force_even),
        .in_valid   (tx_valid),
        .in_data    (tx_data),
        .beat       (beat)
    );

    scsi_par_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .chk_en   (cfg_chk_en),
        .clr      (perr_clr),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_par   (rx_par),
        .err_evt  (perr_evt),
        .err_flag (perr_flag)
    );

    scsi_ofs_ctr #(.OFS_W(OFS_W)) u_ofs (
        .clk     (clk),
        .rst     (rst),
        .inc     (req_sent),
        .dec     (ack_rcvd),
        .count   (offset_cnt),
        .is_zero (ofs_zero)
    );

    assign halt_req = !cfg_no_halt && (atn || perr_evt);
    assign strobe   = dir_rx ? rx_valid : tx_valid;

    scsi_halt_seq #(.SLACK_MAX(SLACK_MAX)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (halt_req),
        .strobe     (strobe),
        .sync_mode  (sync_mode),
        .ofs_zero   (ofs_zero),
        .dir_rx     (dir_rx),
        .fifo_empty (fifo_empty),
        .resume     (resume),
        .pending    (halt_pending),
        .halted     (halt)
    );

    assign tx_out_valid = beat.valid;
    assign tx_out_data  = beat.data;
    assign tx_out_par   = beat.par;
endmodule

// File: rtl/scsi_xfer_ctl_chk.sv
module scsi_xfer_ctl_chk #(
    parameter int OFS_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_no_halt,
    input logic             cfg_force_even,
    input logic             perr_clr,
    input logic             dir_rx,
    input logic             fifo_empty,
    input logic             req_sent,
    input logic             ack_rcvd,
    input logic             tx_out_valid,
    input logic [7:0]       tx_out_data,
    input logic             tx_out_par,
    input logic             perr_flag,
    input logic             halt_pending,
    input logic             halt,
    input logic [OFS_W-1:0] offset_cnt
);
    a_r1_r2_tx_parity: assert property (@(posedge clk) disable iff (rst)
        tx_out_valid |-> ((^{tx_out_data, tx_out_par}) == !$past(cfg_force_even)));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (perr_flag && !perr_clr) |=> perr_flag);

    a_r6_no_halt_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (cfg_no_halt && !halt_pending && !halt) |=> !halt_pending);

    a_r9_drain_before_halt: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> $past(!dir_rx || fifo_empty));

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (offset_cnt == '0 && ack_rcvd && !req_sent) |=> (offset_cnt == '0));

    a_r12_states_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(halt && halt_pending));
endmodule

bind scsi_xfer_ctl scsi_xfer_ctl_chk #(.OFS_W(OFS_W)) u_xfer_chk (.*);

// File: tb/scsi_xfer_ctl_tb_top.sv
module scsi_xfer_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_no_halt, cfg_force_even, cfg_chk_en, perr_clr, resume, dir_rx;
    logic       tx_valid, rx_valid, rx_par, atn, sync_mode, req_sent, ack_rcvd, fifo_empty;
    logic [7:0] tx_data, rx_data;
    logic       tx_out_valid, tx_out_par, perr_flag, halt_pending, halt;
    logic [7:0] tx_out_data;
    logic [4:0] offset_cnt;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_xfer_ctl dut_i (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: present a transmit byte for one cycle and queue its expected output.
    task automatic send_tx(input logic [7:0] d);
        tx_valid = 1'b1;
        tx_data  = d;
        exp_q.push_back({d, cfg_force_even ? (^d) : ~(^d)});
    endtask

    // Monitor: pop and compare each registered transmit beat.
    always @(negedge clk) begin
        if (!rst && tx_out_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R1/R2: actual %0h expected none", {tx_out_data, tx_out_par});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({tx_out_data, tx_out_par} !== e) begin
                    miscompares++;
                    $display("FAIL R1/R2: actual %0h expected %0h", {tx_out_data, tx_out_par}, e);
                end
            end
        end
    end

    task automatic rx_byte(input logic [7:0] d, input logic p);
        rx_valid = 1'b1; rx_data = d; rx_par = p;
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic do_resume();
        resume = 1'b1; cyc(); resume = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {cfg_no_halt, cfg_force_even, cfg_chk_en, perr_clr, resume, dir_rx} = '0;
        {tx_valid, rx_valid, rx_par, atn, sync_mode, req_sent, ack_rcvd} = '0;
        fifo_empty = 1'b1; tx_data = '0; rx_data = '0;
        cyc(); cyc();
        rst = 1'b0;

        // R13 reset state
        chk("R13 halt", halt, 0);
        chk("R13 pending", halt_pending, 0);
        chk("R13 perr", perr_flag, 0);
        chk("R13 txv", tx_out_valid, 0);
        chk("R13 ofs", offset_cnt, 0);

        // R1 odd parity, R2 forced even parity (scoreboard)
        foreach (tx_data[i]) begin
            send_tx(8'h01 << i); cyc();
        end
        send_tx(8'h00); cyc();
        cfg_force_even = 1'b1;
        send_tx(8'h00); cyc();
        send_tx(8'hA7); cyc();
        tx_valid = 1'b0; cfg_force_even = 1'b0;
        cyc();
        chk("R1 queue drained", exp_q.size(), 0);

        // R3 receive checking
        cfg_chk_en = 1'b1; cfg_no_halt = 1'b1;
        cfg_force_even = 1'b1;
        rx_byte(8'h03, 1'b1);
        chk("R3 good byte with force_even", perr_flag, 0);
        cfg_force_even = 1'b0;
        cfg_chk_en = 1'b0;
        rx_byte(8'h03, 1'b0);
        chk("R3 check disabled", perr_flag, 0);
        cfg_chk_en = 1'b1;
        dir_rx = 1'b1;
        rx_byte(8'h03, 1'b0);
        chk("R3 bad byte flagged", perr_flag, 1);
        // R6 disabled halt: flag set but no halt
        chk("R6 no pending on perr", halt_pending, 0);
        atn = 1'b1; cyc(); cyc();
        chk("R6 no pending on atn", halt_pending, 0);
        chk("R6 no halt", halt, 0);
        atn = 1'b0;
        // R4 sticky then cleared
        cyc(); cyc();
        chk("R4 sticky", perr_flag, 1);
        perr_clr = 1'b1; cyc(); perr_clr = 1'b0;
        chk("R4 cleared", perr_flag, 0);
        cfg_no_halt = 1'b0; dir_rx = 1'b0;

        // R5/R7 atn halt, no bytes offered: halt after three edges
        atn = 1'b1; cyc(); atn = 1'b0;
        chk("R5 pending after atn", halt_pending, 1);
        cyc(); cyc();
        chk("R7 not yet halted", halt, 0);
        cyc();
        chk("R7 halt when no bytes offered", halt, 1);
        chk("R7 pending cleared", halt_pending, 0);
        do_resume();
        chk("R12 resume", halt, 0);
        chk("R12 idle", halt_pending, 0);

        // R7/R11 streaming bytes with atn held high throughout
        atn = 1'b1;
        for (int i = 0; i < 4; i++) begin
            send_tx(8'h10 + 8'(i)); cyc();
        end
        chk("R7 still pending after slack", halt_pending, 1);
        chk("R11 not halted yet", halt, 0);
        send_tx(8'h20); cyc();
        chk("R11 no restart, not halted", halt, 0);
        send_tx(8'h21); cyc();
        chk("R7 R11 halt after three slack bytes", halt, 1);
        tx_valid = 1'b0; atn = 1'b0;
        do_resume();
        chk("R12 resume after stream", halt, 0);

        // R10 offset counter
        ack_rcvd = 1'b1; cyc(); ack_rcvd = 1'b0;
        chk("R10 no underflow", offset_cnt, 0);
        req_sent = 1'b1; cyc(); cyc(); req_sent = 1'b0;
        chk("R10 inc", offset_cnt, 2);
        req_sent = 1'b1; ack_rcvd = 1'b1; cyc(); req_sent = 1'b0; ack_rcvd = 1'b0;
        chk("R10 both hold", offset_cnt, 2);

        // R8 sync mode waits on outstanding offsets
        sync_mode = 1'b1;
        atn = 1'b1; cyc(); atn = 1'b0;
        cyc(); cyc(); cyc(); cyc();
        chk("R8 held by offsets", halt, 0);
        chk("R8 still pending", halt_pending, 1);
        ack_rcvd = 1'b1; cyc(); cyc(); ack_rcvd = 1'b0;
        chk("R10 dec to zero", offset_cnt, 0);
        cyc();
        chk("R8 one edge after zero", halt, 0);
        cyc();
        chk("R8 halt after offsets zero", halt, 1);
        sync_mode = 1'b0;
        do_resume();

        // R9 receive parity error halts only after FIFO drains
        dir_rx = 1'b1; fifo_empty = 1'b0;
        rx_byte(8'h55, 1'b0);
        chk("R5 perr triggers pending", halt_pending, 1);
        chk("R4 flag on perr", perr_flag, 1);
        cyc(); cyc(); cyc(); cyc();
        chk("R9 held by FIFO", halt, 0);
        fifo_empty = 1'b1; cyc();
        chk("R9 halt after FIFO empty", halt, 1);
        do_resume();
        chk("R12 resume after rx", halt, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule